// File: doc/BRIEF.md
# Watchdog Timer with Staged Reset

The block is a watchdog that runs on its own clock and escalates in stages. A software-chosen power-of-two interval runs first. When that interval expires without a refresh, the block raises an interrupt flag. A second, shorter grace window then opens, and software can still refresh the watchdog during it. If the grace window also runs out and reset is enabled, the block drives an active-low reset pulse of fixed length and records the cause in a sticky flag.

A wake-up request and a wake flag let a time-out bring the system out of a low-power state. The wake flag tells software afterwards what woke it.

Software reaches the block through two byte-wide registers. A write strobe, a one-bit address and a data byte drive them, and read data is returned combinationally. The control register sits at address 0 and holds these bits:

| Bit | Function |
|---|---|
| 0 | Refresh command (write only) |
| 1 | Reset enable |
| 2 | Reset flag |
| 3 | Interrupt flag |
| 4 | Wake enable |
| 5 | Wake flag |
| 7 | Watchdog enable |

The configuration register sits at address 1. Bits [3:0] select the interval and bits [5:4] select the grace window.

Top module: `wdog_core`

## Requirements
- R1: With interval select s in configuration bits [3:0], the interrupt flag rises 2^(4+2s) clocks after the counter starts. Values of s above 8 act as 8. With the default parameters this gives 2^4 up to 2^20 clocks.
- R2: Interval expiry sets the interrupt flag (control bit 3), and `irq` mirrors that flag.
- R3: Grace select g in configuration bits [5:4] picks a window of 3, 18, 130 or 1026 clocks for g = 0..3. The window is counted from the edge that sets the interrupt flag.
- R4: If reset enable (control bit 1) is 1 and the grace window ends without a refresh, the reset flag (control bit 2) is set on the same edge that drives `wdt_rst_n` low.
- R5: `wdt_rst_n` stays low for exactly 63 clocks. On the edge that releases it, a new interval starts from zero.
- R6: If reset enable is 0, the end of the grace window starts a new interval. `wdt_rst_n` stays high, and the interrupt flag stays set.
- R7: Writing 1 to control bit 0 while an interval or grace window runs restarts the interval from zero and cancels the pending reset. It leaves the interrupt flag unchanged, and bit 0 always reads 0.
- R8: Writing 1 to control bit 2, 3 or 5 clears that flag. Writing 0 leaves it unchanged, and a flag being set on the same edge wins over its clear.
- R9: A new interval select takes effect only at the next counter start. An interval that is already running keeps its length.
- R10: While control bit 7 is 0, the counter is held at zero, no flag is raised, refresh writes have no effect and `wdt_rst_n` stays high. Setting bit 7 starts the interval one clock after the write.
- R11: With wake enable (control bit 4) set, an expiry also sets the wake flag (control bit 5). `wake_req` equals the interrupt flag ANDed with wake enable.
- R12: The reset flag stays set through and after the reset pulse until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 control, 1 configuration |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Time-out interrupt (interrupt flag) |
| wake_req | output | 1 | Wake-up request |
| wdt_rst_n | output | 1 | Active-low system reset pulse |

## Verification
On every cycle, the assertions check several properties:
- The interval counter never passes its latched limit.
- An expiry always sets the interrupt flag, and also the wake flag when wake is enabled.
- Write-one-to-clear works on the interrupt flag.
- The reset flag only changes when it is set or cleared.
- A refresh in the grace window returns to counting.
- Every reset pulse is exactly 63 clocks long and comes with the reset flag.
- A disabled watchdog keeps reset high and raises nothing.

The absolute timing can only be shown by the bench's scenarios, which measure edge counts directly:
- the interval length for each select value, including saturation;
- the grace window length for each select value;
- the restart after a pulse;
- the deferred effect of a changed interval select;
- the cancelling effect of a refresh.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_GRACE = 2'd2,
    PH_RST  = 2'd3
  } wd_phase_e;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned SEL_W  = 4;
  localparam int unsigned GSEL_W = 2;

  // control register bit positions
  localparam int unsigned B_REFRESH = 0;
  localparam int unsigned B_RSTEN   = 1;
  localparam int unsigned B_RSTF    = 2;
  localparam int unsigned B_INTF    = 3;
  localparam int unsigned B_WKEN    = 4;
  localparam int unsigned B_WKF     = 5;
  localparam int unsigned B_EN      = 7;

  localparam logic A_CTL = 1'b0;
  localparam logic A_CFG = 1'b1;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic                expire_i,
  input  logic                fire_i,
  output logic                en_o,
  output logic                rst_en_o,
  output logic                wake_en_o,
  output logic                refresh_o,
  output logic [SEL_W-1:0]    tsel_o,
  output logic [GSEL_W-1:0]   gsel_o,
  output logic                int_flag_o,
  output logic                rst_flag_o,
  output logic                wake_flag_o
);

  logic ctl_wr, cfg_wr;
  logic en_q, rsten_q, wken_q, intf_q, rstf_q, wkf_q;
  logic en_d, rsten_d, wken_d, intf_d, rstf_d, wkf_d;
  logic [SEL_W-1:0]  tsel_q, tsel_d;
  logic [GSEL_W-1:0] gsel_q, gsel_d;
  logic ctl_ld, cfg_ld, flag_ld;

  assign ctl_wr = wr_en && (addr == A_CTL);
  assign cfg_wr = wr_en && (addr == A_CFG);

  always_comb begin
    en_d    = wdata[B_EN];
    rsten_d = wdata[B_RSTEN];
    wken_d  = wdata[B_WKEN];
    tsel_d  = wdata[SEL_W-1:0];
    gsel_d  = wdata[SEL_W+GSEL_W-1:SEL_W];
    // set has priority over write-one-to-clear
    intf_d = intf_q;
    if (ctl_wr && wdata[B_INTF]) intf_d = 1'b0;
    if (expire_i)                intf_d = 1'b1;
    wkf_d = wkf_q;
    if (ctl_wr && wdata[B_WKF])  wkf_d = 1'b0;
    if (expire_i && wken_q)      wkf_d = 1'b1;
    rstf_d = rstf_q;
    if (ctl_wr && wdata[B_RSTF]) rstf_d = 1'b0;
    if (fire_i)                  rstf_d = 1'b1;
  end

  assign ctl_ld  = ctl_wr;
  assign cfg_ld  = cfg_wr;
  assign flag_ld = ctl_wr || expire_i || fire_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      rsten_q <= 1'b0;
      wken_q  <= 1'b0;
    end else if (ctl_ld) begin
      en_q    <= en_d;
      rsten_q <= rsten_d;
      wken_q  <= wken_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsel_q <= '0;
      gsel_q <= '0;
    end else if (cfg_ld) begin
      tsel_q <= tsel_d;
      gsel_q <= gsel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intf_q <= 1'b0;
      wkf_q  <= 1'b0;
      rstf_q <= 1'b0;
    end else if (flag_ld) begin
      intf_q <= intf_d;
      wkf_q  <= wkf_d;
      rstf_q <= rstf_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CTL) begin
      rdata[B_EN]    = en_q;
      rdata[B_RSTEN] = rsten_q;
      rdata[B_WKEN]  = wken_q;
      rdata[B_INTF]  = intf_q;
      rdata[B_WKF]   = wkf_q;
      rdata[B_RSTF]  = rstf_q;
    end else begin
      rdata[SEL_W-1:0]              = tsel_q;
      rdata[SEL_W+GSEL_W-1:SEL_W]   = gsel_q;
    end
  end

  assign en_o        = en_q;
  assign rst_en_o    = rsten_q;
  assign wake_en_o   = wken_q;
  assign refresh_o   = ctl_wr && wdata[B_REFRESH];
  assign tsel_o      = tsel_q;
  assign gsel_o      = gsel_q;
  assign int_flag_o  = intf_q;
  assign rst_flag_o  = rstf_q;
  assign wake_flag_o = wkf_q;

  p_int_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> intf_q);

  p_w1c_int_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wdata[B_INTF] && !expire_i) |=> !intf_q);

  p_wake_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i && wken_q) |=> wkf_q);

  p_rst_flag_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire_i && !(ctl_wr && wdata[B_RSTF])) |=> $stable(rstf_q));

endmodule

// File: rtl/wdog_interval.sv
module wdog_interval
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_EXP = 4,
  parameter int unsigned EXP_STEP = 2,
  parameter int unsigned NUM_SEL  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             count_en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             expire_o
);

  localparam int unsigned MAX_EXP = BASE_EXP + EXP_STEP * (NUM_SEL - 1);
  localparam int unsigned CW      = MAX_EXP + 1;
  localparam logic [SEL_W-1:0] SEL_TOP = SEL_W'(NUM_SEL - 1);

  logic [CW-1:0]    cnt_q, cnt_d, lim_m1;
  logic [SEL_W-1:0] sel_q, sel_sat;
  logic             cnt_ld;
  int unsigned      exp_amt;

  assign sel_sat = (sel_i > SEL_TOP) ? SEL_TOP : sel_i;

  always_comb begin
    exp_amt = BASE_EXP + EXP_STEP * int'(sel_q);
    lim_m1  = (CW'(1) << exp_amt) - CW'(1);
  end

  always_comb begin
    cnt_d  = cnt_q;
    cnt_ld = 1'b0;
    if (!en_i) begin
      cnt_d  = '0;
      cnt_ld = 1'b1;
    end else if (start_i) begin
      cnt_d  = '0;
      cnt_ld = 1'b1;
    end else if (count_en_i) begin
      cnt_d  = (cnt_q == lim_m1) ? '0 : cnt_q + CW'(1);
      cnt_ld = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_ld) cnt_q <= cnt_d;
  end

  // interval length is captured only at a counter start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else if (start_i) sel_q <= sel_sat;
  end

  assign expire_o = en_i && count_en_i && !start_i && (cnt_q == lim_m1);

  p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count_en_i |-> (cnt_q <= lim_m1));

  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && en_i) |=> (cnt_q == '0));

endmodule

// File: rtl/wdog_rst_seq.sv
module wdog_rst_seq
  import wdog_pkg::*;
#(
  parameter int unsigned GRACE_0 = 3,
  parameter int unsigned GRACE_1 = 18,
  parameter int unsigned GRACE_2 = 130,
  parameter int unsigned GRACE_3 = 1026,
  parameter int unsigned RST_LEN = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              refresh_i,
  input  logic              rst_en_i,
  input  logic [GSEL_W-1:0] gsel_i,
  input  logic              expire_i,
  output logic              start_o,
  output logic              count_en_o,
  output logic              fire_o,
  output logic              rst_out_n
);

  localparam int unsigned G_MAX01 = (GRACE_0 > GRACE_1) ? GRACE_0 : GRACE_1;
  localparam int unsigned G_MAX23 = (GRACE_2 > GRACE_3) ? GRACE_2 : GRACE_3;
  localparam int unsigned G_MAX   = (G_MAX01 > G_MAX23) ? G_MAX01 : G_MAX23;
  localparam int unsigned DW      = $clog2(G_MAX) + 1;
  localparam int unsigned PW      = $clog2(RST_LEN) + 1;

  wd_phase_e         ph_q, ph_d;
  logic [DW-1:0]     gcnt_q, gcnt_d, g_m1;
  logic [PW-1:0]     pcnt_q, pcnt_d;
  logic [GSEL_W-1:0] gsel_q;
  logic              rstl_q, rstl_d;
  logic              start, fire;

  always_comb begin
    case (gsel_q)
      2'd0:    g_m1 = DW'(GRACE_0 - 1);
      2'd1:    g_m1 = DW'(GRACE_1 - 1);
      2'd2:    g_m1 = DW'(GRACE_2 - 1);
      default: g_m1 = DW'(GRACE_3 - 1);
    endcase
  end

  always_comb begin
    ph_d   = ph_q;
    gcnt_d = gcnt_q;
    pcnt_d = pcnt_q;
    start  = 1'b0;
    fire   = 1'b0;
    if (!en_i) begin
      ph_d   = PH_IDLE;
      gcnt_d = '0;
      pcnt_d = '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          start = 1'b1;
          ph_d  = PH_RUN;
        end
        PH_RUN: begin
          if (refresh_i) begin
            start = 1'b1;
          end else if (expire_i) begin
            ph_d   = PH_GRACE;
            gcnt_d = '0;
          end
        end
        PH_GRACE: begin
          if (refresh_i) begin
            start = 1'b1;
            ph_d  = PH_RUN;
          end else if (gcnt_q == g_m1) begin
            if (rst_en_i) begin
              fire   = 1'b1;
              ph_d   = PH_RST;
              pcnt_d = '0;
            end else begin
              start = 1'b1;
              ph_d  = PH_RUN;
            end
          end else begin
            gcnt_d = gcnt_q + DW'(1);
          end
        end
        default: begin
          if (pcnt_q == PW'(RST_LEN - 1)) begin
            start = 1'b1;
            ph_d  = PH_RUN;
          end else begin
            pcnt_d = pcnt_q + PW'(1);
          end
        end
      endcase
    end
    rstl_d = (ph_d == PH_RST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      gcnt_q <= '0;
      pcnt_q <= '0;
      rstl_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      gcnt_q <= gcnt_d;
      pcnt_q <= pcnt_d;
      rstl_q <= rstl_d;
    end
  end

  // grace length is captured when the window opens
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gsel_q <= '0;
    else if (expire_i && (ph_q == PH_RUN)) gsel_q <= gsel_i;
  end

  assign start_o    = start;
  assign fire_o     = fire;
  assign count_en_o = en_i && (ph_q == PH_RUN);
  assign rst_out_n  = !rstl_q;

  // pulse-length watch counter used only by the check below
  logic [PW:0] lowrun_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lowrun_q <= '0;
    else if (!rst_out_n) lowrun_q <= lowrun_q + (PW+1)'(1);
    else lowrun_q <= '0;
  end

  p_pulse_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_out_n) && en_i) |-> (lowrun_q == (PW+1)'(RST_LEN)));

  p_refresh_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && refresh_i && (ph_q == PH_GRACE)) |=> ((ph_q == PH_RUN) && rst_out_n));

  p_fire_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out_n) |-> $past(rst_en_i));

endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_EXP    = 4,
  parameter int unsigned EXP_STEP    = 2,
  parameter int unsigned NUM_SEL     = 9,
  parameter int unsigned GRACE_0     = 3,
  parameter int unsigned GRACE_1     = 18,
  parameter int unsigned GRACE_2     = 130,
  parameter int unsigned GRACE_3     = 1026,
  parameter int unsigned RST_LEN     = 63,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              wake_req,
  output logic              wdt_rst_n
);

  logic srst_n;

  generate
    if (SYNC_STAGES < 2) begin : g_sync1
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b0;
        else s_q <= 1'b1;
      end
      assign srst_n = s_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else s_q <= {s_q[SYNC_STAGES-2:0], 1'b1};
      end
      assign srst_n = s_q[SYNC_STAGES-1];
    end
  endgenerate

  logic en, rst_en, wake_en, refresh;
  logic [SEL_W-1:0]  tsel;
  logic [GSEL_W-1:0] gsel;
  logic int_flag, rst_flag, wake_flag;
  logic expire, fire, start, count_en;

  wdog_regs u_regs (
    .clk        (clk),
    .rst_n      (srst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .expire_i   (expire),
    .fire_i     (fire),
    .en_o       (en),
    .rst_en_o   (rst_en),
    .wake_en_o  (wake_en),
    .refresh_o  (refresh),
    .tsel_o     (tsel),
    .gsel_o     (gsel),
    .int_flag_o (int_flag),
    .rst_flag_o (rst_flag),
    .wake_flag_o(wake_flag)
  );

  wdog_interval #(
    .BASE_EXP (BASE_EXP),
    .EXP_STEP (EXP_STEP),
    .NUM_SEL  (NUM_SEL)
  ) u_interval (
    .clk        (clk),
    .rst_n      (srst_n),
    .en_i       (en),
    .start_i    (start),
    .count_en_i (count_en),
    .sel_i      (tsel),
    .expire_o   (expire)
  );

  wdog_rst_seq #(
    .GRACE_0 (GRACE_0),
    .GRACE_1 (GRACE_1),
    .GRACE_2 (GRACE_2),
    .GRACE_3 (GRACE_3),
    .RST_LEN (RST_LEN)
  ) u_seq (
    .clk        (clk),
    .rst_n      (srst_n),
    .en_i       (en),
    .refresh_i  (refresh),
    .rst_en_i   (rst_en),
    .gsel_i     (gsel),
    .expire_i   (expire),
    .start_o    (start),
    .count_en_o (count_en),
    .fire_o     (fire),
    .rst_out_n  (wdt_rst_n)
  );

  assign irq      = int_flag;
  assign wake_req = int_flag && wake_en;

  p_quiet_when_off_r10: assert property (@(posedge clk) disable iff (!srst_n)
    !en |=> (wdt_rst_n && !$rose(int_flag) && !$rose(rst_flag)));

  p_pulse_with_flag_r4: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(wdt_rst_n) |-> rst_flag);

  p_unused_flag_r11: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(wake_flag) |-> int_flag);

endmodule

// File: tb/test_wdog_core.sv
`timescale 1ns/1ps
module test_wdog_core;

  localparam int unsigned BEXP = 2;
  localparam int unsigned STEP = 1;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic       addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       irq, wake_req, wdt_rst_n;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_core #(.BASE_EXP(BEXP), .EXP_STEP(STEP)) i_wdog_core (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .wake_req(wake_req), .wdt_rst_n(wdt_rst_n)
  );

  function automatic int ilen(input int s);
    int e;
    e = (s > 8) ? 8 : s;
    return 1 << (BEXP + STEP * e);
  endfunction

  function automatic int glen(input int g);
    case (g)
      0: return 3;
      1: return 18;
      2: return 130;
      default: return 1026;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 1'b0; wdata = 8'h00;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
    addr = 1'b0;
  endtask

  function automatic bit sig(input int which);
    return (which == 0) ? irq : wdt_rst_n;
  endfunction

  task automatic wait_lvl(input int which, input bit v, output int t);
    int n;
    n = 0;
    while (sig(which) != v && n < 6000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 6000) chk(1'b0, "timeout", n, 0);
    t = cyc;
  endtask

  task automatic off();
    wr(1'b0, 8'h2C);
    repeat (2) @(negedge clk);
  endtask

  logic [7:0] v;
  int t0, t1, t2;

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = 1'b0; wdata = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd(1'b0, v); chk(v == 8'h00, "R10 reset ctl", v, 0);
    rd(1'b1, v); chk(v == 8'h00, "R1 reset cfg", v, 0);
    chk(wdt_rst_n == 1'b1 && irq == 1'b0, "R10 reset outputs", {irq, wdt_rst_n}, 1);

    // R1 / R2 interval sweep including saturation
    for (int s = 0; s < 11; s++) begin
      int sv;
      sv = (s == 10) ? 15 : s;
      wr(1'b1, 8'(sv));
      wr(1'b0, 8'h80);
      t0 = cyc;
      wait_lvl(0, 1'b1, t1);
      chk(t1 - t0 == ilen(sv) + 1, "R1 interval length", t1 - t0, ilen(sv) + 1);
      rd(1'b0, v); chk(v[3] == 1'b1, "R2 int flag bit3", v[3], 1);
      off();
      rd(1'b0, v); chk(v == 8'h00, "R8 flags cleared", v, 0);
    end

    // R3 R4 R5 R12 grace sweep with reset enabled
    for (int g = 0; g < 4; g++) begin
      wr(1'b1, 8'((g << 4) | 2));
      wr(1'b0, 8'h82);
      wait_lvl(0, 1'b1, t0);
      wait_lvl(1, 1'b0, t1);
      chk(t1 - t0 == glen(g), "R3 grace length", t1 - t0, glen(g));
      rd(1'b0, v); chk(v[2] == 1'b1, "R4 reset flag at pulse", v[2], 1);
      wait_lvl(1, 1'b1, t2);
      chk(t2 - t1 == 63, "R5 pulse length", t2 - t1, 63);
      rd(1'b0, v); chk(v[2] == 1'b1, "R12 flag after pulse", v[2], 1);
      wr(1'b0, 8'h8A);
      wait_lvl(0, 1'b1, t0);
      chk(t0 - t2 == ilen(2), "R5 restart after pulse", t0 - t2, ilen(2));
      rd(1'b0, v); chk(v[2] == 1'b1, "R12 flag kept", v[2], 1);
      off();
    end

    // R6 reset disabled: new interval, no pulse
    wr(1'b1, 8'h02);
    wr(1'b0, 8'h80);
    wait_lvl(0, 1'b1, t0);
    wr(1'b0, 8'h88);
    wait_lvl(0, 1'b1, t1);
    chk(t1 - t0 == 3 + ilen(2), "R6 re-expiry", t1 - t0, 3 + ilen(2));
    rd(1'b0, v); chk(v[2] == 1'b0 && wdt_rst_n, "R6 no reset", v[2], 0);
    off();

    // R7 refresh inside grace window
    wr(1'b1, 8'h12);
    wr(1'b0, 8'h82);
    wait_lvl(0, 1'b1, t0);
    repeat (4) @(negedge clk);
    wr(1'b0, 8'h83);
    t1 = cyc;
    rd(1'b0, v);
    chk(v[3] == 1'b1 && v[0] == 1'b0, "R7 int kept, bit0 reads 0", v, 8'h8A);
    wait_lvl(1, 1'b0, t2);
    chk(t2 - t1 == ilen(2) + 18, "R7 reset postponed", t2 - t1, ilen(2) + 18);
    off();
    chk(wdt_rst_n == 1'b1, "R10 disable ends pulse", wdt_rst_n, 1);

    // R7 refresh while counting
    wr(1'b1, 8'h02);
    wr(1'b0, 8'h82);
    repeat (8) @(negedge clk);
    wr(1'b0, 8'h83);
    t0 = cyc;
    wait_lvl(0, 1'b1, t1);
    chk(t1 - t0 == ilen(2), "R7 refresh restarts", t1 - t0, ilen(2));
    off();

    // R11 / R8 wake and selective clear
    wr(1'b1, 8'h04);
    wr(1'b0, 8'h90);
    wait_lvl(0, 1'b1, t0);
    rd(1'b0, v);
    chk(v[5] == 1'b1 && wake_req == 1'b1, "R11 wake flag and request", v, 8'hB8);
    wr(1'b0, 8'h90);
    rd(1'b0, v); chk(v[3] && v[5], "R8 write 0 keeps flags", v, 8'hB8);
    wr(1'b0, 8'h98);
    rd(1'b0, v);
    chk(!v[3] && v[5] && !wake_req, "R8 clear int only", v, 8'hB0);
    wr(1'b0, 8'hB0);
    rd(1'b0, v); chk(v == 8'h90, "R8 clear wake", v, 8'h90);
    off();

    // R9 select change deferred to next start
    wr(1'b1, 8'h04);
    wr(1'b0, 8'h80);
    t0 = cyc;
    repeat (5) @(negedge clk);
    wr(1'b1, 8'h00);
    wait_lvl(0, 1'b1, t1);
    chk(t1 - t0 == ilen(4) + 1, "R9 running interval kept", t1 - t0, ilen(4) + 1);
    wr(1'b0, 8'h88);
    wait_lvl(0, 1'b1, t2);
    chk(t2 - t1 == 3 + ilen(0), "R9 new select at restart", t2 - t1, 3 + ilen(0));
    off();

    // R10 disabled watchdog ignores refresh and raises nothing
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h01);
    repeat (200) @(negedge clk);
    rd(1'b0, v);
    chk(v == 8'h00 && !irq && wdt_rst_n, "R10 quiet when disabled", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule